// File: doc/BRIEF.md
# Wiper Register Controller with Emulated Nonvolatile Copy

This block keeps the 8-bit tap code of a 256-position resistor string. It holds two copies of that code. The first is a volatile working register, which drives the tap output. The second is an emulated nonvolatile byte, which survives commands and supplies the start-up value. A serial frontend, not part of this block, decodes the bus. It hands over three single-cycle strobes: one for the command byte, one for a data byte and one for the STOP condition.

Four command codes are supported. Two write the incoming data byte directly into one copy. The other two transfer a whole copy in one direction or the other. Any command that programs the nonvolatile byte opens a long busy window, counted in clock cycles from the STOP strobe. While that window is open, every command that reads or writes the nonvolatile byte is dropped.

After reset the block runs a timed recall. During the recall the tap output reads zero. At the end of the recall the nonvolatile byte is copied into the working register, and a ready flag asserts.

Top module: `wiper_reg_ctrl`

## Requirements
- R1: While reset is asserted, `tap_code`, `ready` and `nv_busy` are 0. The nonvolatile byte takes the factory value 0x80. `ready` rises exactly RECALL_CYCLES rising edges after reset is released, with `tap_code` then equal to the nonvolatile byte, and it stays high until the next reset.
- R2: While `ready` is low, `tap_code` reads 0. Every command received in that period is dropped.
- R3: Command code 0x11 followed by a data byte loads that byte into the working register. `tap_code` shows it on the edge after the data strobe.
- R4: Command code 0x21 followed by a data byte stores that byte into the nonvolatile copy on the STOP strobe. `tap_code` is left unchanged. Without a data byte the command is dropped.
- R5: Command code 0x61 copies the nonvolatile byte into the working register on the STOP strobe. Any data byte in the frame is ignored.
- R6: Command code 0x51 copies the working register into the nonvolatile byte on the STOP strobe. Any data byte in the frame is ignored.
- R7: Every accepted nonvolatile write drives `nv_busy` high for exactly BUSY_CYCLES cycles. The window starts on the edge that samples the STOP strobe.
- R8: While `nv_busy` is high, codes 0x21, 0x51 and 0x61 are dropped and leave both copies unchanged. Code 0x11 still takes effect.
- R9: Any other command code leaves both copies unchanged and does not raise `nv_busy`.
- R10: Only the first data byte after a command byte is used. A data byte with no command before it is ignored. A new command byte restarts the frame, and a STOP strobe closes it. At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also acts as the power-up event |
| cmd_stb | input | 1 | Command byte strobe, one cycle |
| cmd_byte | input | 8 | Command code, valid with `cmd_stb` |
| dat_stb | input | 1 | Data byte strobe, one cycle |
| dat_byte | input | CODE_W | Data byte, valid with `dat_stb` |
| stop_stb | input | 1 | STOP condition strobe, one cycle |
| tap_code | output | CODE_W | Current wiper tap code |
| nv_busy | output | 1 | Nonvolatile programming window open |
| ready | output | 1 | Start-up recall finished |

## Verification
The embedded properties check these points on every cycle:
- the tap output stays at zero until `ready`;
- `ready` never drops once it is high;
- every load of the working register lands on the next edge;
- a nonvolatile commit always opens the busy window with the committed value in place;
- no commit happens while busy;
- the nonvolatile byte holds its value between commits.

Only the bench scenarios can show the rest:
- the exact recall and busy durations;
- the decoding of each command code;
- that a data byte is ignored by the transfer commands;
- that commands are dropped during the recall and busy windows;
- the frame rules for missing, extra or restarted data bytes.

These are checked against a behavioural model compared on every clock.

// File: rtl/wiper_pkg.sv
// Package: shared command codes and widths for the wiper register controller.
// Assumes command bytes are fully decoded 8-bit codes.
package wiper_pkg;
    localparam int CMD_W = 8;

    typedef enum logic [CMD_W-1:0] {
        CMD_WR_VOL  = 8'h11,   // data byte -> working register
        CMD_WR_NV   = 8'h21,   // data byte -> nonvolatile byte
        CMD_VOL2NV  = 8'h51,   // working register -> nonvolatile byte
        CMD_NV2VOL  = 8'h61    // nonvolatile byte -> working register
    } wiper_cmd_e;
endpackage

// File: rtl/wiper_frame.sv
// Module: wiper_frame
// Captures one bus frame (command byte, first data byte) and decodes it
// into write enables for the two register copies.
// Assumes: at most one strobe per cycle; ready and busy come from the
// register modules and gate every action.
module wiper_frame
    import wiper_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_stb,
    input  logic [CMD_W-1:0]    cmd_byte,
    input  logic                dat_stb,
    input  logic [CODE_W-1:0]   dat_byte,
    input  logic                stop_stb,
    input  logic                ready,
    input  logic                busy,
    input  logic [CODE_W-1:0]   vol_q,
    output logic                vol_wr_en,
    output logic                vol_from_nv,
    output logic                nv_wr_en,
    output logic [CODE_W-1:0]   nv_wr_val
);
    logic               have_cmd;
    logic               have_dat;
    logic [CMD_W-1:0]   cmd_q;
    logic [CODE_W-1:0]  dat_q;

    logic first_dat;
    logic is_vol_wr;
    logic is_nv_wr;
    logic is_v2n;
    logic is_n2v;

    // Frame capture: a command opens the frame, only the first data byte is kept, STOP closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_cmd <= 1'b0;
            have_dat <= 1'b0;
            cmd_q    <= '0;
            dat_q    <= '0;
        end else if (cmd_stb) begin
            have_cmd <= 1'b1;
            have_dat <= 1'b0;
            cmd_q    <= cmd_byte;
        end else if (first_dat) begin
            have_dat <= 1'b1;
            dat_q    <= dat_byte;
        end else if (stop_stb) begin
            have_cmd <= 1'b0;
            have_dat <= 1'b0;
        end
    end

    // Decode of the held command and the gating by ready and busy.
    always_comb begin
        first_dat   = dat_stb && have_cmd && !have_dat;
        is_vol_wr   = (cmd_q == CMD_WR_VOL);
        is_nv_wr    = (cmd_q == CMD_WR_NV);
        is_v2n      = (cmd_q == CMD_VOL2NV);
        is_n2v      = (cmd_q == CMD_NV2VOL);

        vol_from_nv = stop_stb && have_cmd && is_n2v && !busy;
        vol_wr_en   = ready && ((first_dat && is_vol_wr) || vol_from_nv);
        nv_wr_en    = ready && stop_stb && have_cmd && !busy &&
                      ((is_nv_wr && have_dat) || is_v2n);
        nv_wr_val   = is_nv_wr ? dat_q : vol_q;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, dat_stb, stop_stb})); // R10
endmodule

// File: rtl/wiper_nvcell.sv
// Module: wiper_nvcell
// Emulated nonvolatile byte with its programming busy timer.
// Assumes: rst_n models power-up, so the byte returns to the factory value;
// the writer never commits while busy is high.
module wiper_nvcell #(
    parameter int          CODE_W      = 8,
    parameter int          BUSY_CYCLES = 2_400_000,
    parameter logic [CODE_W-1:0] NV_FACTORY = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_wr_en,
    input  logic [CODE_W-1:0] nv_wr_val,
    output logic [CODE_W-1:0] nv_q,
    output logic              busy
);
    localparam int BC_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [BC_W-1:0] BC_LOAD = BC_W'(BUSY_CYCLES);

    logic [BC_W-1:0] busy_cnt;

    // Stored byte: factory value at power-up, replaced on each accepted commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nv_q <= NV_FACTORY;
        else if (nv_wr_en)
            nv_q <= nv_wr_val;
    end

    // Busy timer: loaded on a commit, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (nv_wr_en)
            busy_cnt <= BC_LOAD;
        else if (busy_cnt != '0)
            busy_cnt <= busy_cnt - 1'b1;
    end

    assign busy = (busy_cnt != '0);

    AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_en |=> (busy && nv_q == $past(nv_wr_val))); // R7
    AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !nv_wr_en); // R8
    AST_NV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !nv_wr_en |=> $stable(nv_q)); // R9
endmodule

// File: rtl/wiper_volreg.sv
// Module: wiper_volreg
// Working (volatile) wiper register plus the power-on recall sequencer.
// Assumes: writes are only requested once ready is high.
module wiper_volreg #(
    parameter int CODE_W        = 8,
    parameter int RECALL_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vol_wr_en,
    input  logic [CODE_W-1:0] vol_wr_val,
    input  logic [CODE_W-1:0] nv_q,
    output logic [CODE_W-1:0] vol_q,
    output logic              ready
);
    localparam int RC_W = $clog2(RECALL_CYCLES + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RECALL_CYCLES - 1);

    logic [RC_W-1:0] rc_cnt;
    logic            recall_done;

    assign recall_done = !ready && (rc_cnt == RC_LAST);

    // Recall sequencer: counts the start-up window, then raises ready for good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_cnt <= '0;
            ready  <= 1'b0;
        end else if (!ready) begin
            rc_cnt <= rc_cnt + 1'b1;
            if (recall_done)
                ready <= 1'b1;
        end
    end

    // Working register: zero through recall, loaded from the nonvolatile byte, then from writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vol_q <= '0;
        else if (recall_done)
            vol_q <= nv_q;
        else if (vol_wr_en)
            vol_q <= vol_wr_val;
    end

    AST_ZERO_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (vol_q == '0)); // R2
    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R1
    AST_VOL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        vol_wr_en |=> (vol_q == $past(vol_wr_val))); // R3
endmodule

// File: rtl/wiper_reg_ctrl.sv
// Module: wiper_reg_ctrl (top)
// Holds a 256-tap wiper code in a working register backed by an emulated
// nonvolatile byte, executing four command codes from a serial frontend.
// Assumes: one strobe per cycle; rst_n doubles as the power-up event.
module wiper_reg_ctrl
    import wiper_pkg::*;
#(
    parameter int CODE_W        = 8,
    parameter int RECALL_CYCLES = 2000,
    parameter int BUSY_CYCLES   = 2_400_000,
    parameter logic [CODE_W-1:0] NV_FACTORY = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [7:0]        cmd_byte,
    input  logic              dat_stb,
    input  logic [CODE_W-1:0] dat_byte,
    input  logic              stop_stb,
    output logic [CODE_W-1:0] tap_code,
    output logic              nv_busy,
    output logic              ready
);
    logic              vol_wr_en;
    logic              vol_from_nv;
    logic [CODE_W-1:0] vol_wr_val;
    logic              nv_wr_en;
    logic [CODE_W-1:0] nv_wr_val;
    logic [CODE_W-1:0] nv_q;
    logic [CODE_W-1:0] vol_q;

    wiper_frame #(.CODE_W(CODE_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb    (cmd_stb),
        .cmd_byte   (cmd_byte),
        .dat_stb    (dat_stb),
        .dat_byte   (dat_byte),
        .stop_stb   (stop_stb),
        .ready      (ready),
        .busy       (nv_busy),
        .vol_q      (vol_q),
        .vol_wr_en  (vol_wr_en),
        .vol_from_nv(vol_from_nv),
        .nv_wr_en   (nv_wr_en),
        .nv_wr_val  (nv_wr_val)
    );

    // Source select for the working register: transfer from the stored byte or the bus byte.
    assign vol_wr_val = vol_from_nv ? nv_q : dat_byte;

    wiper_nvcell #(
        .CODE_W     (CODE_W),
        .BUSY_CYCLES(BUSY_CYCLES),
        .NV_FACTORY (NV_FACTORY)
    ) u_nv (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_wr_en (nv_wr_en),
        .nv_wr_val(nv_wr_val),
        .nv_q     (nv_q),
        .busy     (nv_busy)
    );

    wiper_volreg #(
        .CODE_W       (CODE_W),
        .RECALL_CYCLES(RECALL_CYCLES)
    ) u_vol (
        .clk       (clk),
        .rst_n     (rst_n),
        .vol_wr_en (vol_wr_en),
        .vol_wr_val(vol_wr_val),
        .nv_q      (nv_q),
        .vol_q     (vol_q),
        .ready     (ready)
    );

    assign tap_code = vol_q;
endmodule

// File: tb/sim_wiper_reg_ctrl.sv
module sim_wiper_reg_ctrl;
    localparam int RCY = 8;
    localparam int BCY = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_stb = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       dat_stb = 1'b0;
    logic [7:0] dat_byte = 8'h00;
    logic       stop_stb = 1'b0;
    logic [7:0] tap_code;
    logic       nv_busy;
    logic       ready;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    wiper_reg_ctrl #(.RECALL_CYCLES(RCY), .BUSY_CYCLES(BCY)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
        .dat_stb(dat_stb), .dat_byte(dat_byte), .stop_stb(stop_stb),
        .tap_code(tap_code), .nv_busy(nv_busy), .ready(ready));

    // Behavioural reference model, advanced on every rising edge.
    int m_vol, m_nv, m_bc, m_rc, f_cmd, f_dat;
    bit m_rdy, f_cv, f_dv, r0, b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vol = 0; m_nv = 128; m_bc = 0; m_rc = 0; m_rdy = 0;
            f_cv = 0; f_dv = 0; f_cmd = 0; f_dat = 0;
        end else begin
            r0 = m_rdy;
            b0 = (m_bc != 0);
            if (m_bc > 0) m_bc = m_bc - 1;
            if (!r0) begin
                m_rc = m_rc + 1;
                if (m_rc == RCY) begin m_rdy = 1; m_vol = m_nv; end
            end else begin
                if (dat_stb && f_cv && !f_dv && f_cmd == 'h11) m_vol = dat_byte;
                if (stop_stb && f_cv && !b0) begin
                    if (f_cmd == 'h21 && f_dv) begin m_nv = f_dat; m_bc = BCY; end
                    else if (f_cmd == 'h51) begin m_nv = m_vol; m_bc = BCY; end
                    else if (f_cmd == 'h61) m_vol = m_nv;
                end
            end
            if (cmd_stb) begin f_cv = 1; f_dv = 0; f_cmd = cmd_byte; end
            else if (dat_stb && f_cv && !f_dv) begin f_dv = 1; f_dat = dat_byte; end
            else if (stop_stb) begin f_cv = 0; f_dv = 0; end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "model tap_code", int'(tap_code), m_vol & 'hff);
            chk(cur_req, "model nv_busy", int'(nv_busy), int'(m_bc != 0));
            chk(cur_req, "model ready", int'(ready), int'(m_rdy));
        end
    end

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk); cmd_stb = 1'b1; cmd_byte = c;
        @(negedge clk); cmd_stb = 1'b0;
    endtask
    task automatic send_dat(input logic [7:0] d);
        @(negedge clk); dat_stb = 1'b1; dat_byte = d;
        @(negedge clk); dat_stb = 1'b0;
    endtask
    task automatic send_stop();
        @(negedge clk); stop_stb = 1'b1;
        @(negedge clk); stop_stb = 1'b0;
    endtask
    task automatic wait_idle();
        while (nv_busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1", "reset tap_code", int'(tap_code), 0);
        chk("R1", "reset ready", int'(ready), 0);
        chk("R1", "reset nv_busy", int'(nv_busy), 0);
        rst_n = 1'b1;
        // R2: a write sent during recall is dropped; tap reads zero
        cur_req = "R2";
        n = 0;
        @(negedge clk); cmd_stb = 1; cmd_byte = 8'h11; n++;
        @(negedge clk); cmd_stb = 0; dat_stb = 1; dat_byte = 8'h55; n++;
        @(negedge clk); dat_stb = 0; stop_stb = 1; n++;
        @(negedge clk); stop_stb = 0; n++;
        chk("R2", "tap during recall", int'(tap_code), 0);
        cur_req = "R1";
        while (!ready) begin @(negedge clk); n++; end
        chk("R1", "recall length", n, RCY);
        chk("R1", "recalled factory value", int'(tap_code), 'h80);

        cur_req = "R3";
        send_cmd(8'h11); send_dat(8'h3C);
        chk("R3", "tap after volatile write", int'(tap_code), 'h3C);
        send_stop();

        cur_req = "R4";
        send_cmd(8'h21); send_dat(8'hA5); send_stop();
        chk("R4", "tap unchanged by nv write", int'(tap_code), 'h3C);
        cur_req = "R7";
        n = 0;
        while (nv_busy) begin n++; @(negedge clk); end
        chk("R7", "busy length", n, BCY);

        cur_req = "R5";
        send_cmd(8'h61); send_dat(8'h00); send_stop();
        chk("R5", "tap after nv->vol", int'(tap_code), 'hA5);

        cur_req = "R6";
        send_cmd(8'h11); send_dat(8'h11); send_stop();
        send_cmd(8'h51); send_dat(8'hFF); send_stop();
        chk("R6", "busy after vol->nv", int'(nv_busy), 1);
        // R8: drops while busy, volatile write proceeds
        cur_req = "R8";
        send_cmd(8'h21); send_dat(8'h99); send_stop();
        send_cmd(8'h61); send_stop();
        chk("R8", "nv->vol dropped while busy", int'(tap_code), 'h11);
        send_cmd(8'h11); send_dat(8'h44); send_stop();
        chk("R8", "volatile write while busy", int'(tap_code), 'h44);
        wait_idle();
        send_cmd(8'h61); send_stop();
        chk("R6", "nv holds copied value", int'(tap_code), 'h11);
        wait_idle();

        cur_req = "R9";
        send_cmd(8'h31); send_dat(8'h77); send_stop();
        chk("R9", "unknown code tap", int'(tap_code), 'h11);
        chk("R9", "unknown code busy", int'(nv_busy), 0);
        send_cmd(8'h10); send_dat(8'h78); send_stop();
        send_cmd(8'h61); send_stop();
        chk("R9", "nv unchanged by unknown", int'(tap_code), 'h11);

        cur_req = "R10";
        send_cmd(8'h11); send_dat(8'h66); send_dat(8'h77); send_stop();
        chk("R10", "first data byte only", int'(tap_code), 'h66);
        send_dat(8'h12); send_stop();
        chk("R10", "data without command", int'(tap_code), 'h66);
        send_cmd(8'h21); send_stop();
        chk("R4", "nv write without data", int'(nv_busy), 0);
        send_cmd(8'h21); send_cmd(8'h11); send_dat(8'h5A); send_stop();
        chk("R10", "restarted frame tap", int'(tap_code), 'h5A);
        chk("R10", "restarted frame busy", int'(nv_busy), 0);
        send_cmd(8'h61); send_stop();
        chk("R10", "nv still A5-free copy", int'(tap_code), 'h11);
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule